// File: doc/BRIEF.md
# UART Control Register with Interrupt Gating, Break and Loopback

This block sits between a UART serial core and the rest of the chip. It holds an eight-bit control register that software writes through a simple strobe port and can read back at any time. Two of its bits enable the receiver and the transmitter in the core. A third forces the serial output low to send a break. Two more decide whether the receive-side and transmit-side service conditions may raise the single interrupt line. The last one turns on an internal loopback.

The interrupt output is a level signal. It is the OR of four terms. The receive-FIFO service flag and the receiver-idle flag pass only while the receive interrupt enable is set. The transmit-FIFO service flag passes only while the transmit interrupt enable is set. An error-in-FIFO flag from the receive path always passes. In loopback, the transmit shifter output, after the break override, is fed into the receive shifter input. The external transmit pin is then parked at the idle level, the external receive pin is ignored, and an ownership output tells an alternate pin-control unit that it now owns both pins.

Top module: `uart_cw_top`

## Requirements
- R1: After reset the control register reads 0x00, both enables are low, the ownership output is low, and the transmit pin follows the transmit shifter output.
- R2: A write with `wr_en` high updates the control register at the next rising clock edge. The bit positions are: receive enable at bit 0, transmit enable at bit 1, break at bit 2, receive interrupt enable at bit 3, transmit interrupt enable at bit 4 and loopback at bit 5. `rd_data` returns these six bits in those positions.
- R3: Bits 7 and 6 always read 0, whatever value is written to them.
- R4: While bit 3 is set, `rx_svc` drives `irq`. While bit 3 is clear, `rx_svc` has no effect on `irq`.
- R5: While bit 3 is set, `rx_idle` drives `irq`. While bit 3 is clear, `rx_idle` has no effect on `irq`.
- R6: While bit 4 is set, `tx_svc` drives `irq`. While bit 4 is clear, `tx_svc` has no effect on `irq`.
- R7: `err_fifo` drives `irq` whatever the control bits are. `irq` is low whenever no enabled term is high.
- R8: While bit 2 is set and bit 5 is clear, `txd_pin` is 0 whatever the shifter output is.
- R9: While bit 5 is clear, `txd_pin` follows `sh_txd` (unless a break is active), `sh_rxd` follows `rxd_pin`, and `pin_alt_own` is 0.
- R10: While bit 5 is set, `sh_rxd` equals the transmit line after the break override (0 during a break, otherwise `sh_txd`). In the same state `txd_pin` is 1, `rxd_pin` has no effect, and `pin_alt_own` is 1.
- R11: `rx_en` and `tx_en` equal control bits 0 and 1.
- R12: With `wr_en` low, `wr_data` has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| rx_svc | input | 1 | Receive FIFO needs service |
| rx_idle | input | 1 | Receiver idle condition |
| tx_svc | input | 1 | Transmit FIFO half full or less |
| err_fifo | input | 1 | Error flagged in the bottom receive FIFO entries |
| irq | output | 1 | Combined interrupt level |
| rx_en | output | 1 | Receiver enable to the core |
| tx_en | output | 1 | Transmitter enable to the core |
| sh_txd | input | 1 | Transmit shifter serial output |
| sh_rxd | output | 1 | Receive shifter serial input |
| txd_pin | output | 1 | External transmit pin |
| rxd_pin | input | 1 | External receive pin |
| pin_alt_own | output | 1 | Alternate pin-control unit owns the pins |

## Verification
The bench sets a break and loopback together. A design that looped back the raw shifter bit would show the receiver a toggling line instead of a steady zero. A design that let the break reach the pin would drive the parked pin low. The bench writes all ones to the reserved bits and drives `wr_data` while the strobe is low. A design that kept the reserved bits would read back 0xC0-style values, and one with a loose strobe would change the register. The bench also toggles each status flag with only the other enable set, to catch a receive flag wired to the transmit enable or the error term left gated.

// File: rtl/uart_cw_pkg.sv
package uart_cw_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_RXE  = 0;
  localparam int BIT_TXE  = 1;
  localparam int BIT_BRK  = 2;
  localparam int BIT_RIEN = 3;
  localparam int BIT_TIEN = 4;
  localparam int BIT_LOOP = 5;
  localparam logic [REG_W-1:0] WR_MASK = 8'h3F;

  typedef struct packed {
    logic loop;
    logic tien;
    logic rien;
    logic brk;
    logic txe;
    logic rxe;
  } ctl_t;

  function automatic ctl_t unpack_ctl(input logic [REG_W-1:0] r);
    ctl_t c;
    c.rxe  = r[BIT_RXE];
    c.txe  = r[BIT_TXE];
    c.brk  = r[BIT_BRK];
    c.rien = r[BIT_RIEN];
    c.tien = r[BIT_TIEN];
    c.loop = r[BIT_LOOP];
    return c;
  endfunction

  // transmit line level after the break override
  function automatic logic tx_line(input logic brk, input logic shifter);
    return brk ? 1'b0 : shifter;
  endfunction
endpackage

// File: rtl/uart_cw_ctlreg.sv
module uart_cw_ctlreg
  import uart_cw_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] MASK = WR_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] reg_q
);
  logic         wr_fire;
  logic [W-1:0] wr_masked;

  assign wr_fire   = wr_en;
  assign wr_masked = wr_data & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else if (wr_fire) reg_q <= wr_masked;
  end

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> reg_q == ($past(wr_data) & MASK)); // R2
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q & ~MASK) == '0); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q)); // R12
endmodule

// File: rtl/uart_cw_irqgate.sv
module uart_cw_irqgate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] term;

  for (genvar i = 0; i < N; i++) begin : g_term
    assign term[i] = src[i] & en[i];
  end

  assign irq = |term;

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((src & en) != '0)); // R7
endmodule

// File: rtl/uart_cw_pinmux.sv
module uart_cw_pinmux
  import uart_cw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic loop,
  input  logic sh_txd,
  output logic sh_rxd,
  output logic txd_pin,
  input  logic rxd_pin,
  output logic pin_alt_own
);
  logic line_tx;

  assign line_tx     = tx_line(brk, sh_txd);
  assign txd_pin     = loop ? 1'b1 : line_tx;
  assign sh_rxd      = loop ? line_tx : rxd_pin;
  assign pin_alt_own = loop;

  AST_LOOP_BRK_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (loop && brk) |-> !sh_rxd); // R10
  AST_NORM_RX: assert property (@(posedge clk) disable iff (!rst_n)
    !loop |-> sh_rxd == rxd_pin); // R9
endmodule

// File: rtl/uart_cw_top.sv
module uart_cw_top
  import uart_cw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             rx_svc,
  input  logic             rx_idle,
  input  logic             tx_svc,
  input  logic             err_fifo,
  output logic             irq,
  output logic             rx_en,
  output logic             tx_en,
  input  logic             sh_txd,
  output logic             sh_rxd,
  output logic             txd_pin,
  input  logic             rxd_pin,
  output logic             pin_alt_own
);
  localparam int NSRC = 4;

  logic [REG_W-1:0] reg_q;
  ctl_t             ctl;
  logic [NSRC-1:0]  irq_src;
  logic [NSRC-1:0]  irq_en;

  uart_cw_ctlreg #(.W(REG_W), .MASK(WR_MASK)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .reg_q(reg_q)
  );

  assign ctl     = unpack_ctl(reg_q);
  assign rd_data = reg_q;
  assign rx_en   = ctl.rxe;
  assign tx_en   = ctl.txe;

  assign irq_src = {err_fifo, tx_svc, rx_idle, rx_svc};
  assign irq_en  = {1'b1, ctl.tien, ctl.rien, ctl.rien};

  uart_cw_irqgate #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .src(irq_src), .en(irq_en), .irq(irq)
  );

  uart_cw_pinmux u_pins (
    .clk(clk), .rst_n(rst_n), .brk(ctl.brk), .loop(ctl.loop),
    .sh_txd(sh_txd), .sh_rxd(sh_rxd), .txd_pin(txd_pin),
    .rxd_pin(rxd_pin), .pin_alt_own(pin_alt_own)
  );

  AST_ERR_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    err_fifo |-> irq); // R7
  AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[BIT_RIEN] && !err_fifo && !(rd_data[BIT_TIEN] && tx_svc)) |-> !irq); // R4
  AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BIT_TIEN] && tx_svc) |-> irq); // R6
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BIT_RIEN] && rx_idle) |-> irq); // R5
  AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[BIT_BRK] && !rd_data[BIT_LOOP]) |-> !txd_pin); // R8
  AST_LOOP_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BIT_LOOP] |-> (txd_pin && pin_alt_own)); // R10
  AST_EN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en == rd_data[BIT_RXE]) && (tx_en == rd_data[BIT_TXE])); // R11
endmodule

// File: tb/uart_cw_top_test.sv
module uart_cw_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rx_svc = 1'b0, rx_idle = 1'b0, tx_svc = 1'b0, err_fifo = 1'b0;
  logic       irq, rx_en, tx_en;
  logic       sh_txd = 1'b1;
  logic       sh_rxd, txd_pin, pin_alt_own;
  logic       rxd_pin = 1'b1;

  int vectors = 0;
  int fails = 0;
  int model_ctl = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_cw_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rx_svc(rx_svc), .rx_idle(rx_idle), .tx_svc(tx_svc), .err_fifo(err_fifo),
    .irq(irq), .rx_en(rx_en), .tx_en(tx_en), .sh_txd(sh_txd), .sh_rxd(sh_rxd),
    .txd_pin(txd_pin), .rxd_pin(rxd_pin), .pin_alt_own(pin_alt_own)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference expectations, computed from the requirement text
  task automatic compare_all(input string tag);
    int  loop_on, brk_on, line, exp_irq;
    loop_on = (model_ctl / 32) % 2;
    brk_on  = (model_ctl / 4) % 2;
    line    = brk_on ? 0 : int'(sh_txd);
    exp_irq = 0;
    if (err_fifo) exp_irq = 1;
    if (((model_ctl / 8) % 2 == 1) && (rx_svc || rx_idle)) exp_irq = 1;
    if (((model_ctl / 16) % 2 == 1) && tx_svc) exp_irq = 1;
    chk("R2/R3", {tag, " rd_data"}, int'(rd_data), model_ctl);
    chk("R4/R5/R6/R7", {tag, " irq"}, int'(irq), exp_irq);
    chk("R11", {tag, " rx_en"}, int'(rx_en), model_ctl % 2);
    chk("R11", {tag, " tx_en"}, int'(tx_en), (model_ctl / 2) % 2);
    if (loop_on == 1) begin
      chk("R10", {tag, " txd_pin"}, int'(txd_pin), 1);
      chk("R10", {tag, " sh_rxd"}, int'(sh_rxd), line);
      chk("R10", {tag, " own"}, int'(pin_alt_own), 1);
    end else begin
      if (brk_on == 1) chk("R8", {tag, " txd_pin"}, int'(txd_pin), 0);
      else chk("R9", {tag, " txd_pin"}, int'(txd_pin), line);
      chk("R9", {tag, " sh_rxd"}, int'(sh_rxd), int'(rxd_pin));
      chk("R9", {tag, " own"}, int'(pin_alt_own), 0);
    end
  endtask

  // one cycle: drive at the falling edge, check, then let the rising edge act
  task automatic step(input string tag, input bit we, input logic [7:0] d,
                      input logic [3:0] st, input bit stx, input bit rxp);
    @(negedge clk);
    wr_en = we; wr_data = d;
    {err_fifo, tx_svc, rx_idle, rx_svc} = st;
    sh_txd = stx; rxd_pin = rxp;
    #1;
    compare_all(tag);
    if (we) model_ctl = int'(d) % 64; // R3: bits 7..6 dropped
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
    end
  end

  initial begin
    #5;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rd_data at reset", int'(rd_data), 0);
    chk("R1", "rx_en at reset", int'(rx_en), 0);
    chk("R1", "own at reset", int'(pin_alt_own), 0);
    sh_txd = 1'b0; #1;
    chk("R1", "txd follows shifter", int'(txd_pin), 0);
    rst_n = 1'b1;

    // R12: strobe low, data ignored
    step("R12 nostrobe", 0, 8'hFF, 4'h0, 1, 1);
    step("R12 after", 0, 8'h00, 4'h0, 1, 1);
    // R3: reserved bits written high
    step("R3 write", 1, 8'hC3, 4'h0, 1, 0);
    step("R3 read", 0, 8'h00, 4'h0, 0, 1);
    // R4/R5 masked, R6 passed
    step("R4 masked", 1, 8'h10, 4'b0011, 1, 1);
    step("R4 masked2", 0, 8'h00, 4'b0011, 1, 1);
    step("R6 pass", 0, 8'h00, 4'b0100, 1, 1);
    // R4/R5 enabled, R6 masked
    step("R5 en", 1, 8'h08, 4'b0100, 1, 1);
    step("R5 idle", 0, 8'h00, 4'b0010, 1, 1);
    step("R4 svc", 0, 8'h00, 4'b0001, 1, 1);
    step("R6 masked", 0, 8'h00, 4'b0100, 1, 1);
    // R7: error with nothing enabled
    step("R7 clr", 1, 8'h00, 4'b1000, 1, 1);
    step("R7 err", 0, 8'h00, 4'b1000, 0, 0);
    // R8: break on the pin
    step("R8 set", 1, 8'h06, 4'h0, 1, 1);
    step("R8 hi", 0, 8'h00, 4'h0, 1, 1);
    step("R8 lo", 0, 8'h00, 4'h0, 0, 0);
    // R10: loopback without break, then with break
    step("R10 set", 1, 8'h21, 4'h0, 1, 0);
    step("R10 sh1", 0, 8'h00, 4'h0, 1, 0);
    step("R10 sh0", 0, 8'h00, 4'h0, 0, 1);
    step("R10 brk", 1, 8'h24, 4'h0, 1, 1);
    step("R10 brk hi", 0, 8'h00, 4'h0, 1, 0);
    step("R10 brk lo", 0, 8'h00, 4'h0, 0, 1);
    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      logic [3:0] s;
      d = 8'($urandom);
      s = 4'($urandom);
      step("rand", ($urandom % 3) == 0, d, s, 1'($urandom), 1'($urandom));
    end
    done = 1;
    finish_run();
  end
endmodule